// File: doc/BRIEF.md
# Linked-List Address Translate Unit

This unit sits in the read path between the processor and the cache. It lets unmodified list-walking code traverse rows of a sparse structure after the row's elements have been gathered into a packed, reserved cache region. When the processor loads a row's head pointer from the root pointer array, the unit starts a gather of that row. It answers with the reserved-region address of the first slot in place of the stored pointer. When the processor later loads the next-element pointer of an element in that region, the unit answers with the address of the following slot. For the last element it answers with null.

Every element occupies one fixed-size slot (64 bytes by default), packed from the region base. The byte offset of the next pointer inside a slot is configured. The gather engine reports how many elements it placed, and the unit keeps that count for the current row. All other reads are returned with the cache's data in the same cycle, so the unit adds no latency. The gather engine and the data storage are outside this block.

Top module: `ll_xlate_unit`

## Requirements
- R1: A valid read whose address falls inside the root array (`cfg_root_base_i` up to `cfg_row_count_i` pointers of 4 bytes, 4-byte aligned) and whose cache data is non-zero responds in the same cycle with `cfg_rsv_base_i`.
- R2: Such a read raises `gather_start_o` for exactly one cycle, one cycle after the read. `gather_row_o` carries the row index (address minus root base, divided by 4) and `gather_ptr_o` carries the original cache data.
- R3: A root array read whose cache data is zero responds with zero, starts no gather, and leaves the current row mapping and count untouched.
- R4: A valid read inside the reserved region (MAX_SLOTS slots of SLOT_BYTES bytes from `cfg_rsv_base_i`) whose offset within its slot equals `cfg_next_off_i` responds with `cfg_rsv_base_i + (k+1)*SLOT_BYTES` when slot k is not the last slot of the row (k+1 < count).
- R5: Such a next-field read responds with zero when k+1 is not below the stored count, including while no count has been reported since the last row start.
- R6: Every other valid read (other slot offsets, misaligned root addresses, addresses outside both windows) responds with `cache_data_i` unchanged in the same cycle, and `rsp_valid_o` always equals `req_valid_i`.
- R7: A row start (a root read with non-zero data) resets the stored count to zero. A `gather_done_i` in the same cycle is ignored.
- R8: `gather_done_i` loads `gather_count_i` as the row's element count, limited to MAX_SLOTS.
- R9: The window edges are exact. The last root entry and the last slot are intercepted. The first address past the root array and the first slot position past the region are passed through.
- R10: With `req_valid_i` low, no response is flagged and no gather is started, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_root_base_i | input | AW | Byte address of the root pointer array |
| cfg_row_count_i | input | ROW_W | Number of entries in the root array |
| cfg_rsv_base_i | input | AW | Base address of the reserved slot region |
| cfg_next_off_i | input | log2(SLOT_BYTES) | Byte offset of the next pointer inside a slot |
| req_valid_i | input | 1 | Processor read valid |
| req_addr_i | input | AW | Processor read address |
| cache_data_i | input | AW | Data the cache returns for this read |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | AW | Response data, possibly translated |
| gather_start_o | output | 1 | One-cycle command to gather a row |
| gather_row_o | output | ROW_W | Row index to gather |
| gather_ptr_o | output | AW | Real head pointer of that row |
| gather_done_i | input | 1 | Gather engine reports a finished row |
| gather_count_i | input | CIN_W | Elements placed by the gather engine |

## Verification
The hardest situations to reach from the ports involve the stored count. The bench drives it past MAX_SLOTS to show the limit. Reading slot 254 must still yield the address of slot 255, and reading slot 255 must yield null rather than an address past the region. A second hard case is a gather completion that lands in the same cycle as a new row start. The bench drives both together and then reads slot 0, which must return null because the count was cleared. A null root read between rows shows the old mapping survives: the following next-field read still links to slot 1.

// File: rtl/ll_xlate_pkg.sv
package ll_xlate_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_ROOT = 2'd1,
    HIT_NEXT = 2'd2
  } hit_e;
endpackage

// File: rtl/ll_root_decode.sv
module ll_root_decode #(
  parameter int AW        = 32,
  parameter int ROW_W     = 16,
  parameter int PTR_BYTES = 4
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [AW-1:0]    base_i,
  input  logic [ROW_W-1:0] rows_i,
  output logic             hit_o,
  output logic [ROW_W-1:0] row_idx_o
);
  localparam int PSH    = $clog2(PTR_BYTES);
  localparam int IDX_AW = AW - PSH;

  logic [AW:0] diff;
  logic        in_range;

  assign diff      = {1'b0, addr_i} - {1'b0, base_i};
  assign in_range  = diff[AW-1:PSH] < IDX_AW'(rows_i);
  assign hit_o     = !diff[AW] && (diff[PSH-1:0] == '0) && in_range;
  assign row_idx_o = diff[PSH+ROW_W-1:PSH];
endmodule

// File: rtl/ll_slot_decode.sv
module ll_slot_decode #(
  parameter int AW         = 32,
  parameter int SLOT_BYTES = 64,
  parameter int MAX_SLOTS  = 256
) (
  input  logic [AW-1:0]                 addr_i,
  input  logic [AW-1:0]                 base_i,
  input  logic [$clog2(SLOT_BYTES)-1:0] off_i,
  output logic                          hit_o,
  output logic [$clog2(MAX_SLOTS)-1:0]  slot_idx_o
);
  localparam int SSH    = $clog2(SLOT_BYTES);
  localparam int IDX_W  = $clog2(MAX_SLOTS);
  localparam int HI_W   = AW - SSH;

  logic [AW:0] diff;
  logic        in_region;

  assign diff       = {1'b0, addr_i} - {1'b0, base_i};
  assign in_region  = diff[AW-1:SSH] < HI_W'(MAX_SLOTS);
  assign hit_o      = !diff[AW] && in_region && (diff[SSH-1:0] == off_i);
  assign slot_idx_o = diff[SSH+IDX_W-1:SSH];
endmodule

// File: rtl/ll_row_state.sv
module ll_row_state #(
  parameter int AW        = 32,
  parameter int ROW_W     = 16,
  parameter int MAX_SLOTS = 256,
  parameter int CIN_W     = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [ROW_W-1:0]               row_idx_i,
  input  logic [AW-1:0]                  root_ptr_i,
  input  logic                           done_i,
  input  logic [CIN_W-1:0]               done_cnt_i,
  output logic [$clog2(MAX_SLOTS+1)-1:0] count_o,
  output logic                           gather_start_o,
  output logic [ROW_W-1:0]               gather_row_o,
  output logic [AW-1:0]                  gather_ptr_o
);
  localparam int CNT_W = $clog2(MAX_SLOTS + 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cnt_capped;

  assign cnt_capped = (done_cnt_i > CIN_W'(MAX_SLOTS)) ? CNT_W'(MAX_SLOTS)
                                                       : done_cnt_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (start_i) begin
      count_q <= '0;                // new row abandons old mapping
    end else if (done_i) begin
      count_q <= cnt_capped;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gather_start_o <= 1'b0;
      gather_row_o   <= '0;
      gather_ptr_o   <= '0;
    end else begin
      gather_start_o <= start_i;
      if (start_i) begin
        gather_row_o <= row_idx_i;
        gather_ptr_o <= root_ptr_i;
      end
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/ll_xlate_unit.sv
module ll_xlate_unit
  import ll_xlate_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ROW_W      = 16,
  parameter int SLOT_BYTES = 64,
  parameter int MAX_SLOTS  = 256,
  parameter int CIN_W      = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [AW-1:0]                 cfg_root_base_i,
  input  logic [ROW_W-1:0]              cfg_row_count_i,
  input  logic [AW-1:0]                 cfg_rsv_base_i,
  input  logic [$clog2(SLOT_BYTES)-1:0] cfg_next_off_i,
  input  logic                          req_valid_i,
  input  logic [AW-1:0]                 req_addr_i,
  input  logic [AW-1:0]                 cache_data_i,
  output logic                          rsp_valid_o,
  output logic [AW-1:0]                 rsp_data_o,
  output logic                          gather_start_o,
  output logic [ROW_W-1:0]              gather_row_o,
  output logic [AW-1:0]                 gather_ptr_o,
  input  logic                          gather_done_i,
  input  logic [CIN_W-1:0]              gather_count_i
);
  localparam int SSH       = $clog2(SLOT_BYTES);
  localparam int IDX_W     = $clog2(MAX_SLOTS);
  localparam int CNT_W     = $clog2(MAX_SLOTS + 1);
  localparam int PTR_BYTES = AW / 8;

  logic             hit_root;
  logic             hit_next;
  logic [ROW_W-1:0] row_idx;
  logic [IDX_W-1:0] slot_idx;
  logic [CNT_W-1:0] slot_cnt_q;
  logic [CNT_W-1:0] next_idx;
  logic [AW-1:0]    next_addr;
  logic             root_fire;
  hit_e             kind;

  ll_root_decode #(
    .AW(AW), .ROW_W(ROW_W), .PTR_BYTES(PTR_BYTES)
  ) u_root_dec (
    .addr_i    (req_addr_i),
    .base_i    (cfg_root_base_i),
    .rows_i    (cfg_row_count_i),
    .hit_o     (hit_root),
    .row_idx_o (row_idx)
  );

  ll_slot_decode #(
    .AW(AW), .SLOT_BYTES(SLOT_BYTES), .MAX_SLOTS(MAX_SLOTS)
  ) u_slot_dec (
    .addr_i     (req_addr_i),
    .base_i     (cfg_rsv_base_i),
    .off_i      (cfg_next_off_i),
    .hit_o      (hit_next),
    .slot_idx_o (slot_idx)
  );

  // root window wins if the two windows overlap
  always_comb begin
    if (!req_valid_i)  kind = HIT_NONE;
    else if (hit_root) kind = HIT_ROOT;
    else if (hit_next) kind = HIT_NEXT;
    else               kind = HIT_NONE;
  end

  assign root_fire = (kind == HIT_ROOT) && (cache_data_i != '0);

  ll_row_state #(
    .AW(AW), .ROW_W(ROW_W), .MAX_SLOTS(MAX_SLOTS), .CIN_W(CIN_W)
  ) u_row_state (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (root_fire),
    .row_idx_i      (row_idx),
    .root_ptr_i     (cache_data_i),
    .done_i         (gather_done_i),
    .done_cnt_i     (gather_count_i),
    .count_o        (slot_cnt_q),
    .gather_start_o (gather_start_o),
    .gather_row_o   (gather_row_o),
    .gather_ptr_o   (gather_ptr_o)
  );

  assign next_idx  = {1'b0, slot_idx} + CNT_W'(1);
  assign next_addr = (next_idx < slot_cnt_q)
                     ? cfg_rsv_base_i + (AW'(next_idx) << SSH)
                     : '0;

  always_comb begin
    unique case (kind)
      HIT_ROOT: rsp_data_o = (cache_data_i != '0) ? cfg_rsv_base_i : '0;
      HIT_NEXT: rsp_data_o = next_addr;
      default:  rsp_data_o = cache_data_i;
    endcase
  end

  assign rsp_valid_o = req_valid_i;
endmodule

// File: rtl/ll_xlate_chk.sv
module ll_xlate_chk #(
  parameter int AW        = 32,
  parameter int ROW_W     = 16,
  parameter int MAX_SLOTS = 256
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_valid_i,
  input logic [AW-1:0]                  cache_data_i,
  input logic [AW-1:0]                  cfg_rsv_base_i,
  input logic                           rsp_valid_o,
  input logic [AW-1:0]                  rsp_data_o,
  input logic                           gather_start_o,
  input logic [ROW_W-1:0]               gather_row_o,
  input logic [AW-1:0]                  gather_ptr_o,
  input logic                           hit_root,
  input logic                           hit_next,
  input logic [ROW_W-1:0]               row_idx,
  input logic [$clog2(MAX_SLOTS+1)-1:0] slot_cnt_q
);
  a_r1_root_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && hit_root && (cache_data_i != '0) |-> rsp_data_o == cfg_rsv_base_i);

  a_r2_gather_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && hit_root && (cache_data_i != '0) |=>
      gather_start_o && gather_row_o == $past(row_idx) && gather_ptr_o == $past(cache_data_i));

  a_r5_null_unknown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !hit_root && hit_next && slot_cnt_q == '0 |-> rsp_data_o == '0);

  a_r6_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !hit_root && !hit_next |-> rsp_data_o == cache_data_i);

  a_r6_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == req_valid_i);

  a_r7_count_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && hit_root && (cache_data_i != '0) |=> slot_cnt_q == '0);

  a_r8_count_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_cnt_q <= ($clog2(MAX_SLOTS+1))'(MAX_SLOTS));

  a_r10_no_idle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gather_start_o |-> $past(req_valid_i));
endmodule

bind ll_xlate_unit ll_xlate_chk #(
  .AW(AW), .ROW_W(ROW_W), .MAX_SLOTS(MAX_SLOTS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .cache_data_i   (cache_data_i),
  .cfg_rsv_base_i (cfg_rsv_base_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_data_o     (rsp_data_o),
  .gather_start_o (gather_start_o),
  .gather_row_o   (gather_row_o),
  .gather_ptr_o   (gather_ptr_o),
  .hit_root       (hit_root),
  .hit_next       (hit_next),
  .row_idx        (row_idx),
  .slot_cnt_q     (slot_cnt_q)
);

// File: tb/ll_xlate_unit_tb.sv
module ll_xlate_unit_tb;
  localparam int AW = 32;
  localparam int ROW_W = 16;
  localparam int CIN_W = 16;
  localparam logic [31:0] ROOT = 32'h0000_1000;
  localparam logic [31:0] RSV  = 32'h8000_0000;
  localparam logic [5:0]  OFF  = 6'h18;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [AW-1:0] cache_data_i = '0;
  logic gather_done_i = 1'b0;
  logic [CIN_W-1:0] gather_count_i = '0;
  logic rsp_valid_o, gather_start_o;
  logic [AW-1:0] rsp_data_o, gather_ptr_o;
  logic [ROW_W-1:0] gather_row_o;

  always #5 clk_i = ~clk_i;

  ll_xlate_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_root_base_i(ROOT), .cfg_row_count_i(16'd8),
    .cfg_rsv_base_i(RSV), .cfg_next_off_i(OFF),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .cache_data_i(cache_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .gather_start_o(gather_start_o), .gather_row_o(gather_row_o), .gather_ptr_o(gather_ptr_o),
    .gather_done_i(gather_done_i), .gather_count_i(gather_count_i)
  );

  typedef struct {
    logic        rv;
    logic [31:0] d;
    logic        gs;
    logic [15:0] row;
    logic [31:0] ptr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done_run = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one call per cycle
  task automatic step(logic v, logic [31:0] a, logic [31:0] cd, logic dn, logic [15:0] cnt,
                      logic [31:0] ed, logic gs, logic [15:0] row, logic [31:0] ptr, string tag);
    exp_t e;
    @(negedge clk_i);
    req_valid_i = v; req_addr_i = a; cache_data_i = cd;
    gather_done_i = dn; gather_count_i = cnt;
    e.rv = v; e.d = ed; e.gs = gs; e.row = row; e.ptr = ptr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 32'h0, 32'h0, 0, 0, 32'h0, 0, 0, 0, tag);
  endtask

  // monitor: response of this cycle, gather of the previous one
  initial begin
    exp_t prev, cur;
    prev.gs = 0; prev.row = 0; prev.ptr = 0; prev.tag = "R10";
    forever begin
      @(negedge clk_i);
      #2;
      if (q.size() > 0) begin
        cur = q.pop_front();
        chk({cur.tag, " rsp_valid"}, {31'b0, rsp_valid_o}, {31'b0, cur.rv});
        if (cur.rv) chk({cur.tag, " rsp_data"}, rsp_data_o, cur.d);
        chk({prev.tag, " gather_start"}, {31'b0, gather_start_o}, {31'b0, prev.gs});
        if (prev.gs) begin
          chk({prev.tag, " gather_row"}, {16'b0, gather_row_o}, {16'b0, prev.row});
          chk({prev.tag, " gather_ptr"}, gather_ptr_o, prev.ptr);
        end
        prev = cur;
      end
    end
  end

  initial begin
    #200000;
    if (!done_run) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset rsp_valid", {31'b0, rsp_valid_o}, 32'h0);
    chk("R2 reset gather_start", {31'b0, gather_start_o}, 32'h0);
    rst_ni = 1'b1;
    idle("R10");
    // R5: no count yet
    step(1, RSV + 32'h18, 32'h0000_1234, 0, 0, 32'h0, 0, 0, 0, "R5");
    // R1/R2: row 2 start
    step(1, ROOT + 32'h8, 32'h0004_0000, 0, 0, RSV, 1, 16'd2, 32'h0004_0000, "R1");
    // R8: three elements placed
    step(0, 32'h0, 32'h0, 1, 16'd3, 32'h0, 0, 0, 0, "R8");
    // R4 walk
    step(1, RSV + 32'h18, 32'h0000_dead, 0, 0, RSV + 32'h40, 0, 0, 0, "R4");
    step(1, RSV + 32'h58, 32'h0000_beef, 0, 0, RSV + 32'h80, 0, 0, 0, "R4");
    step(1, RSV + 32'h98, 32'h0000_cafe, 0, 0, 32'h0, 0, 0, 0, "R5");
    // R6 pass-through
    step(1, RSV + 32'h10, 32'h0000_abcd, 0, 0, 32'h0000_abcd, 0, 0, 0, "R6");
    step(1, 32'h0000_2000, 32'h0000_0055, 0, 0, 32'h0000_0055, 0, 0, 0, "R6");
    step(1, ROOT + 32'h9, 32'h0000_0077, 0, 0, 32'h0000_0077, 0, 0, 0, "R6");
    // R9 edges
    step(1, ROOT + 32'h20, 32'h0000_0099, 0, 0, 32'h0000_0099, 0, 0, 0, "R9");
    step(1, RSV + 32'h4018, 32'h0000_0066, 0, 0, 32'h0000_0066, 0, 0, 0, "R9");
    // R3: null root, mapping kept
    step(1, ROOT, 32'h0, 0, 0, 32'h0, 0, 0, 0, "R3");
    step(1, RSV + 32'h18, 32'h0000_0011, 0, 0, RSV + 32'h40, 0, 0, 0, "R3");
    // R9 last root entry, R7 count cleared
    step(1, ROOT + 32'h1C, 32'h0000_0300, 0, 0, RSV, 1, 16'd7, 32'h0000_0300, "R9");
    step(1, RSV + 32'h18, 32'h0000_0022, 0, 0, 32'h0, 0, 0, 0, "R7");
    // R8 cap: 1000 limited to 256
    step(0, 32'h0, 32'h0, 1, 16'd1000, 32'h0, 0, 0, 0, "R8");
    step(1, RSV + 32'h3F98, 32'h0000_0033, 0, 0, RSV + 32'h3FC0, 0, 0, 0, "R8");
    step(1, RSV + 32'h3FD8, 32'h0000_0044, 0, 0, 32'h0, 0, 0, 0, "R8");
    // R7: done in same cycle as row start is dropped
    step(1, ROOT + 32'h4, 32'h0000_0500, 1, 16'd5, RSV, 1, 16'd1, 32'h0000_0500, "R7");
    step(1, RSV + 32'h18, 32'h0000_0088, 0, 0, 32'h0, 0, 0, 0, "R7");
    // R10: invalid request with root address
    step(0, ROOT + 32'hC, 32'h0000_0600, 0, 0, 32'h0, 0, 0, 0, "R10");
    idle("R10");
    idle("R10");
    @(negedge clk_i);
    #4;
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule